// File: doc/BRIEF.md
# Sample Decimator and Sign Formatter

This block conditions one channel's stream of 32-bit sample words before they are framed. Each incoming sample is first brought into a clean numeric form. The sample is read as a full 32-bit value or as a 16-bit half-word. A programmable bit position marks its top bit. Every bit above that position is then filled with the sign (signed mode) or cleared (unsigned mode).

The formatted samples then pass through a rate decimator with a 16-bit divisor N. The sample stream is cut into consecutive windows of N samples. Each window yields one result: the last sample of the window, or, with averaging on, the window's sum divided by N. A divisor of 0 or 1 keeps the full rate.

In 16-bit mode every input word carries two samples, low half first. Sample counting runs across word boundaries. Two results are packed into one output word. The block has a single register stage on the output. Configuration is held stable while samples flow, and a reset starts a new run.

Top module: `sample_decim_fmt`

## Requirements
- R1: After reset `outValid` is 0, and it stays 0 until a sample window completes.
- R2: With a divisor of 0 or 1 in 32-bit mode, every input word produces an output word on the clock edge that accepts it (one register of latency), and `outValid` follows `inValid` cycle for cycle.
- R3: With divisor N ≥ 2 and averaging off, exactly one output appears per N samples. Its value is the formatted last sample of the window. In 32-bit mode two outputs are never on consecutive cycles.
- R4: With averaging on, the result is the sum of the window's formatted samples divided by N, truncated toward zero. The sum is a signed sum when `cfgSignEn`=1 and an unsigned sum when it is 0.
- R5: The averaging sum never overflows. A window of 65535 samples of 0xFFFFFFFF in unsigned mode averages to 0xFFFFFFFF.
- R6: With `cfgSignEn`=1, every bit above position `cfgSignPos` is replaced by the bit at `cfgSignPos`. Position 31 in 32-bit mode leaves the word unchanged.
- R7: With `cfgSignEn`=0, every bit above position `cfgSignPos` is cleared.
- R8: With `cfgWide`=0, bits [15:0] hold the first sample and bits [31:16] the second. Positions above 15 act as 15, and each result keeps its low 16 bits. The first result goes to output bits [15:0] and the second to bits [31:16].
- R9: In 16-bit mode, windows count samples, not words, so a window may end in the middle of a word. The packed output word is emitted on the cycle its second result is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input word present |
| inData | input | 32 | Input sample word |
| cfgDivisor | input | 16 | Decimation divisor N (0 and 1 mean no decimation) |
| cfgAvgEn | input | 1 | 1: output the window average; 0: output the last sample of the window |
| cfgSignPos | input | 5 | Bit position of the sign bit |
| cfgWide | input | 1 | 1: one 32-bit sample per word; 0: two 16-bit samples per word |
| cfgSignEn | input | 1 | 1: signed (sign fill); 0: unsigned (zero fill) |
| outValid | output | 1 | Output word present |
| outData | output | 32 | Formatted, decimated result word |

## Verification
The bench first targets the sign point. One sample has its sign bit set and one clear, at a low position. A formatter that used the wrong bit, or filled in unsigned mode, would show wrong upper bits. The averaging cases use a negative sum and an unsigned sum that crosses 2^32. A design that rounded toward minus infinity, or summed in the wrong signedness, would return -2 or 0 instead of -1 and 0x80000000. A 65535-sample window of all-ones exposes an accumulator that is one bit short. The 16-bit runs use a divisor of 3, so that a window ends in the middle of a word. A design that counted words, swapped halves or emitted too early would produce the pair at the wrong time or in the wrong order.

// File: rtl/sdf_pkg.sv
`timescale 1ns/1ps
package sdf_pkg;

  // Strobes from the control to the datapath, valid in the current cycle
  typedef struct packed {
    logic accLoad;   // a word is accepted: update the running sum
    logic loFirst;   // low lane opens a new window
    logic hiFirst;   // high lane opens a new window
    logic outFire;   // load the output register this cycle
    logic pairNow;   // both lanes close a window in this word
    logic selHi;     // the single closing lane is the high lane
    logic pendLoad;  // park a lone half-result for later packing
  } sdfStrobes_t;

endpackage

// File: rtl/sdf_ctrl.sv
`timescale 1ns/1ps
module sdf_ctrl
  import sdf_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [DIV_W-1:0] cfgDivisor,
  input  logic             cfgWide,
  output sdfStrobes_t      stb
);

  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] cntMid;
  logic [DIV_W-1:0] cntEnd;
  logic [DIV_W-1:0] lastIdx;
  logic             havePend;
  logic             loClose;
  logic             hiClose;
  logic             single;

  // Window bookkeeping: low lane first, then high lane (16-bit mode only)
  always_comb begin
    lastIdx = (cfgDivisor == '0) ? '0 : cfgDivisor - 1'b1;
    loClose = (cnt == lastIdx);
    cntMid  = loClose ? '0 : cnt + 1'b1;
    hiClose = !cfgWide && (cntMid == lastIdx);
    cntEnd  = hiClose ? '0 : cntMid + 1'b1;
  end

  always_comb begin
    single       = inValid && (loClose ^ hiClose);
    stb.accLoad  = inValid;
    stb.loFirst  = (cnt == '0);
    stb.hiFirst  = (cntMid == '0);
    stb.pairNow  = '0;
    stb.selHi    = '0;
    stb.pendLoad = '0;
    stb.outFire  = '0;
    if (cfgWide) begin
      stb.outFire = inValid && loClose;
    end else begin
      stb.pairNow  = inValid && loClose && hiClose;
      stb.selHi    = hiClose && !loClose;
      stb.pendLoad = single && !havePend;
      stb.outFire  = stb.pairNow || (single && havePend);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt      <= '0;
      havePend <= 1'b0;
    end else begin
      if (inValid) cnt <= cfgWide ? cntMid : cntEnd;
      if (cfgWide) havePend <= 1'b0;
      else if (single) havePend <= !havePend;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= lastIdx); // R3

  AST_PEND_NARROW: assert property (@(posedge clk) disable iff (!rstN)
    havePend |-> !cfgWide); // R8

endmodule

// File: rtl/sdf_datapath.sv
`timescale 1ns/1ps
module sdf_datapath
  import sdf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DIV_W  = 16,
  parameter int POS_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] inData,
  input  logic [DIV_W-1:0]  cfgDivisor,
  input  logic              cfgAvgEn,
  input  logic [POS_W-1:0]  cfgSignPos,
  input  logic              cfgWide,
  input  logic              cfgSignEn,
  input  sdfStrobes_t       stb,
  output logic              outValid,
  output logic [DATA_W-1:0] outData
);

  localparam int HALF_W = DATA_W / 2;
  localparam int ACC_W  = DATA_W + DIV_W + 1;
  localparam int LANES  = 2;

  function automatic logic [DATA_W-1:0] fmtWord(input logic [DATA_W-1:0] raw,
                                                input logic [POS_W-1:0]  pos,
                                                input logic              sgn);
    logic [DATA_W-1:0] keep;
    logic              fill;
    keep = {DATA_W{1'b1}} >> (DATA_W - 1 - int'(pos));
    fill = sgn & raw[pos];
    return (raw & keep) | ({DATA_W{fill}} & ~keep);
  endfunction

  function automatic logic signed [ACC_W-1:0] widen(input logic [DATA_W-1:0] v,
                                                    input logic              sgn);
    return sgn ? {{(ACC_W-DATA_W){v[DATA_W-1]}}, v} : {{(ACC_W-DATA_W){1'b0}}, v};
  endfunction

  logic [POS_W-1:0]         posEff;
  logic [DATA_W-1:0]        laneRaw [LANES];
  logic [DATA_W-1:0]        laneFmt [LANES];
  logic signed [ACC_W-1:0]  acc;
  logic signed [ACC_W-1:0]  accLoNew;
  logic signed [ACC_W-1:0]  accHiNew;
  logic signed [ACC_W-1:0]  divS;
  logic [DIV_W-1:0]         divEff;
  logic [DATA_W-1:0]        resLo;
  logic [HALF_W-1:0]        resHi;
  logic [HALF_W-1:0]        single;
  logic [HALF_W-1:0]        pend;
  logic [DATA_W-1:0]        chkKeep;

  // 16-bit mode caps the sign point at the half-word top bit
  assign posEff = (!cfgWide && (cfgSignPos > POS_W'(HALF_W - 1))) ?
                  POS_W'(HALF_W - 1) : cfgSignPos;

  for (genvar l = 0; l < LANES; l++) begin : gLane
    if (l == 0) begin : gLow
      assign laneRaw[l] = cfgWide ? inData : {{HALF_W{1'b0}}, inData[HALF_W-1:0]};
    end else begin : gHigh
      assign laneRaw[l] = {{HALF_W{1'b0}}, inData[DATA_W-1:HALF_W]};
    end
    assign laneFmt[l] = fmtWord(laneRaw[l], posEff, cfgSignEn);
  end

  // Two chained accumulate steps, low lane then high lane
  always_comb begin
    divEff   = (cfgDivisor == '0) ? DIV_W'(1) : cfgDivisor;
    divS     = $signed({{(ACC_W-DIV_W){1'b0}}, divEff});
    accLoNew = (stb.loFirst ? '0 : acc) + widen(laneFmt[0], cfgSignEn);
    accHiNew = (stb.hiFirst ? '0 : accLoNew) + widen(laneFmt[1], cfgSignEn);
    resLo    = cfgAvgEn ? DATA_W'(accLoNew / divS) : laneFmt[0];
    resHi    = cfgAvgEn ? HALF_W'(accHiNew / divS) : laneFmt[1][HALF_W-1:0];
    single   = stb.selHi ? resHi : resLo[HALF_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc      <= '0;
      pend     <= '0;
      outValid <= 1'b0;
      outData  <= '0;
    end else begin
      if (stb.accLoad) acc <= cfgWide ? accLoNew : accHiNew;
      if (stb.pendLoad) pend <= single;
      outValid <= stb.outFire;
      if (stb.outFire) begin
        if (cfgWide)          outData <= resLo;
        else if (stb.pairNow) outData <= {resHi, resLo[HALF_W-1:0]};
        else                  outData <= {single, pend};
      end
    end
  end

  assign chkKeep = {DATA_W{1'b1}} >> (DATA_W - 1 - int'(cfgSignPos));

  AST_ZERO_FILL: assert property (@(posedge clk) disable iff (!rstN)
    outValid && cfgWide && !cfgSignEn |-> (outData & ~chkKeep) == '0); // R7

  AST_SIGN_FILL: assert property (@(posedge clk) disable iff (!rstN)
    outValid && cfgWide && cfgSignEn |->
      (outData & ~chkKeep) == (outData[cfgSignPos] ? ~chkKeep : '0)); // R6

endmodule

// File: rtl/sample_decim_fmt.sv
`timescale 1ns/1ps
module sample_decim_fmt
  import sdf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DIV_W  = 16,
  parameter int POS_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inData,
  input  logic [DIV_W-1:0]  cfgDivisor,
  input  logic              cfgAvgEn,
  input  logic [POS_W-1:0]  cfgSignPos,
  input  logic              cfgWide,
  input  logic              cfgSignEn,
  output logic              outValid,
  output logic [DATA_W-1:0] outData
);

  sdfStrobes_t stb;

  sdf_ctrl #(.DIV_W(DIV_W)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .inValid    (inValid),
    .cfgDivisor (cfgDivisor),
    .cfgWide    (cfgWide),
    .stb        (stb)
  );

  sdf_datapath #(.DATA_W(DATA_W), .DIV_W(DIV_W), .POS_W(POS_W)) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .inData     (inData),
    .cfgDivisor (cfgDivisor),
    .cfgAvgEn   (cfgAvgEn),
    .cfgSignPos (cfgSignPos),
    .cfgWide    (cfgWide),
    .cfgSignEn  (cfgSignEn),
    .stb        (stb),
    .outValid   (outValid),
    .outData    (outData)
  );

  AST_FULL_RATE: assert property (@(posedge clk) disable iff (!rstN)
    inValid && cfgWide && (cfgDivisor <= DIV_W'(1)) |=> outValid); // R2

  AST_DECIM_GAP: assert property (@(posedge clk) disable iff (!rstN)
    outValid && cfgWide && (cfgDivisor >= DIV_W'(2)) |=> !outValid); // R3

endmodule

// File: tb/tb_sample_decim_fmt.sv
`timescale 1ns/1ps
module tb_sample_decim_fmt;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] inData = '0;
  logic [15:0] cfgDivisor = '0;
  logic        cfgAvgEn = 1'b0;
  logic [4:0]  cfgSignPos = 5'd31;
  logic        cfgWide = 1'b1;
  logic        cfgSignEn = 1'b1;
  logic        outValid;
  logic [31:0] outData;

  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = ~clk;

  sample_decim_fmt dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .cfgDivisor(cfgDivisor), .cfgAvgEn(cfgAvgEn), .cfgSignPos(cfgSignPos),
    .cfgWide(cfgWide), .cfgSignEn(cfgSignEn),
    .outValid(outValid), .outData(outData)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic setup(input logic [15:0] div, input logic avg, input logic [4:0] pos,
                       input logic wide, input logic sgn);
    @(posedge clk); #1;
    rstN = 1'b0; inValid = 1'b0;
    cfgDivisor = div; cfgAvgEn = avg; cfgSignPos = pos; cfgWide = wide; cfgSignEn = sgn;
    repeat (2) @(posedge clk);
    #1 rstN = 1'b1;
  endtask

  // Present one word for one edge; the registered result is visible on return
  task automatic sendWord(input logic [31:0] w);
    inValid = 1'b1; inData = w;
    @(posedge clk); #1;
    inValid = 1'b0;
  endtask

  task automatic expectOut(input string req, input logic [31:0] exp);
    check(outValid === 1'b1, {req, " valid"}, {31'b0, outValid}, 32'h1);
    check(outData === exp, {req, " data"}, outData, exp);
  endtask

  task automatic tReset();
    setup(16'd0, 1'b0, 5'd31, 1'b1, 1'b1);
    check(outValid === 1'b0, "R1 reset valid", {31'b0, outValid}, 32'h0);
    check(outData === 32'h0, "R1 reset data", outData, 32'h0);
  endtask

  task automatic tPassThrough();
    logic [31:0] w [4] = '{32'hDEADBEEF, 32'h00000001, 32'h80000000, 32'h7FFFFFFF};
    setup(16'd0, 1'b0, 5'd31, 1'b1, 1'b1);
    for (int i = 0; i < 4; i++) begin
      sendWord(w[i]);
      expectOut("R2 R6 pass", w[i]);
    end
    @(posedge clk); #1;
    check(outValid === 1'b0, "R2 idle", {31'b0, outValid}, 32'h0);
  endtask

  task automatic tSignPoint();
    setup(16'd1, 1'b0, 5'd7, 1'b1, 1'b1);
    sendWord(32'h12345680); expectOut("R6 neg", 32'hFFFFFF80);
    sendWord(32'h1234567F); expectOut("R6 pos", 32'h0000007F);
    setup(16'd1, 1'b0, 5'd7, 1'b1, 1'b0);
    sendWord(32'hABCDEF90); expectOut("R7 clear", 32'h00000090);
  endtask

  task automatic tPick();
    setup(16'd3, 1'b0, 5'd31, 1'b1, 1'b1);
    for (int i = 0; i < 9; i++) begin
      sendWord(32'd10 + 32'(i));
      if (i % 3 == 2) expectOut("R3 pick", 32'd10 + 32'(i));
      else check(outValid === 1'b0, "R3 gap", {31'b0, outValid}, 32'h0);
    end
  endtask

  task automatic tAverage();
    logic [31:0] s [4] = '{32'd5, -32'sd3, -32'sd8, 32'd1};
    setup(16'd4, 1'b1, 5'd31, 1'b1, 1'b1);
    for (int i = 0; i < 4; i++) sendWord(s[i]);
    expectOut("R4 signed trunc", 32'hFFFFFFFF);
    setup(16'd2, 1'b1, 5'd31, 1'b1, 1'b0);
    sendWord(32'hFFFFFFFF);
    check(outValid === 1'b0, "R4 mid window", {31'b0, outValid}, 32'h0);
    sendWord(32'h00000001);
    expectOut("R4 unsigned", 32'h80000000);
    setup(16'd2, 1'b1, 5'd31, 1'b1, 1'b1);
    sendWord(32'hFFFFFFFF); sendWord(32'h00000001);
    expectOut("R4 signed zero", 32'h00000000);
  endtask

  task automatic tLongWindow();
    int early = 0;
    setup(16'd65535, 1'b1, 5'd31, 1'b1, 1'b0);
    for (int i = 0; i < 65534; i++) begin
      sendWord(32'hFFFFFFFF);
      if (outValid) early++;
    end
    check(early == 0, "R5 early output", 32'(early), 32'h0);
    sendWord(32'hFFFFFFFF);
    expectOut("R5 no overflow", 32'hFFFFFFFF);
  endtask

  task automatic tHalfWords();
    setup(16'd1, 1'b0, 5'd7, 1'b0, 1'b1);
    sendWord(32'h0080017F); expectOut("R8 order/sign", 32'hFF80007F);
    setup(16'd0, 1'b0, 5'd20, 1'b0, 1'b0);
    sendWord(32'h80011234); expectOut("R8 pos cap", 32'h80011234);
    setup(16'd3, 1'b0, 5'd15, 1'b0, 1'b1);
    sendWord(32'h00020001);
    check(outValid === 1'b0, "R9 w0", {31'b0, outValid}, 32'h0);
    sendWord(32'h00040003);
    check(outValid === 1'b0, "R9 w1", {31'b0, outValid}, 32'h0);
    sendWord(32'h00060005); expectOut("R9 pick pair", 32'h00060003);
    setup(16'd3, 1'b1, 5'd15, 1'b0, 1'b1);
    sendWord(32'h00020001); sendWord(32'h00040003);
    check(outValid === 1'b0, "R9 avg wait", {31'b0, outValid}, 32'h0);
    sendWord(32'h00060005); expectOut("R9 avg pair", 32'h00050002);
  endtask

  initial begin
    tReset();
    tPassThrough();
    tSignPoint();
    tPick();
    tAverage();
    tHalfWords();
    tLongWindow();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule